// File: doc/BRIEF.md
# Byte-Wide Command/Response Mailbox

This block is the device-side register interface of a byte-wide mailbox that sits on a small host I/O bus with one address bit. Offset 0 is the data port in both directions. Offset 1 returns a status byte on reads and takes a command byte on writes. The host opens a command frame with a start command, writes its payload bytes one at a time into an input holding register, and closes the frame with an end command. Each accepted byte is handed to the core as a valid/ready stream, and the end of the frame is signalled to the core with a one-cycle pulse.

When the core starts presenting its answer, the block frames it for the host. It first places a mode byte (0x01) in the output holding register with the frame-marker flag set. It then passes the core's payload bytes through one at a time with the marker clear. It closes with an end byte (0x03) with the marker set. The block does not interpret the payload. A valid answer carries a big-endian 32-bit length in bytes 2 to 5 and is therefore at least 6 bytes long. A cancel command is taken in any phase and returns the port to the ready-for-command state.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the status byte reads 0x10: only ready-for-command (bit 4) is set. Output-buffer-full (bit 0), input-buffer-full (bit 1), frame marker (bit 2), last-write-was-command (bit 3) and ready-for-data (bit 5) are clear.
- R2: Command 0x01 written to offset 1 while ready-for-command is set clears bit 4 and sets ready-for-data (bit 5).
- R3: A data-port write accepted while ready-for-data is set raises input-buffer-full and presents the byte on the core request stream. The flag drops in the cycle after the core takes the byte.
- R4: A data-port write made while ready-for-data is clear, or while input-buffer-full is set, is dropped and sets the sticky core-side error output. The next accepted 0x01 command clears that output.
- R5: Command 0x03 written while ready-for-data is set ends the frame. It pulses the core end-of-frame output for one cycle and clears ready-for-data.
- R6: The first valid core response byte makes the output buffer hold 0x01 with output-buffer-full and the frame marker set. That core byte is not taken at this point.
- R7: A host read of offset 0 clears output-buffer-full. Each following core byte is then taken, with a ready pulse, and shown with the frame marker clear. Bytes arrive in the order the core sent them.
- R8: After the host reads the core byte marked last, the output buffer holds 0x03 with the frame marker set. Once that byte is read, ready-for-command returns.
- R9: Command 0x22 is accepted in every phase. It empties both holding registers, clears the flags, returns to ready-for-command and pulses the cancel output.
- R10: Status bit 3 shows whether the most recent host write went to offset 1 (set) or offset 0 (clear).
- R11: A command code that does not fit the current phase (0x03 while idle, 0x01 while receiving) leaves the phase and flags unchanged.
- R12: Status bits 7:6 read zero, and ready-for-command and ready-for-data are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host bus access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write access, 0 = read access |
| host_addr | input | 1 | 0 = data port, 1 = status/command |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational from the address) |
| req_valid | output | 1 | Request byte available to the core |
| req_data | output | 8 | Request byte |
| req_ready | input | 1 | Core takes the request byte |
| req_end | output | 1 | One-cycle pulse: command frame closed |
| rsp_valid | input | 1 | Core response byte available |
| rsp_data | input | 8 | Core response byte |
| rsp_last | input | 1 | Marks the final core response byte |
| rsp_ready | output | 1 | Response byte taken this cycle |
| cancel_done | output | 1 | One-cycle pulse after a cancel command |
| data_err | output | 1 | Sticky: a host data write was dropped |

## Verification
The assertions assume that the host makes at most one access per cycle and holds the access strobe for a single cycle. They also assume that the core keeps its response byte and last marker steady until the byte is taken. The bench drives every host access as a one-cycle strobe framed by falling clock edges. It changes the response byte only in the cycle after it sees the ready pulse. It polls status before each data-port read, as a real host would.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the command mailbox.
// Assumes byte-wide host and core paths; command codes are fixed protocol values.
package mbx_pkg;
    localparam int BYTE_W = 8;

    localparam logic [7:0] CODE_START  = 8'h01;
    localparam logic [7:0] CODE_END    = 8'h03;
    localparam logic [7:0] CODE_ABORT  = 8'h22;

    localparam int ST_OBF = 0;
    localparam int ST_IBF = 1;
    localparam int ST_MRK = 2;
    localparam int ST_CMW = 3;
    localparam int ST_RDC = 4;
    localparam int ST_RDD = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RECV,
        PH_WAIT,
        PH_BODY,
        PH_TAIL,
        PH_DRAIN
    } phase_t;
endpackage

// File: rtl/mbx_cmd_fsm.sv
`timescale 1ns/1ps
// Command decoder and phase sequencer.
// Decodes host command writes, steps through receive / response framing phases,
// and generates the load strobes for the output buffer.
// Assumes the output-buffer-full flag comes from mbx_out_buf.
module mbx_cmd_fsm #(
    parameter int DATA_W = mbx_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_code,
    input  logic              obf,
    input  logic              rsp_valid,
    input  logic              rsp_last,
    output mbx_pkg::phase_t   phase,
    output logic              start_evt,
    output logic              abort_evt,
    output logic              load_head,
    output logic              load_body,
    output logic              load_tail,
    output logic              frame_end,
    output logic              abort_pulse
);
    import mbx_pkg::*;

    localparam logic [DATA_W-1:0] K_START = DATA_W'(CODE_START);
    localparam logic [DATA_W-1:0] K_END   = DATA_W'(CODE_END);
    localparam logic [DATA_W-1:0] K_ABORT = DATA_W'(CODE_ABORT);

    phase_t phase_q, phase_d;
    logic   end_evt;

    // Decode command writes that are legal in the current phase.
    always_comb begin
        abort_evt = cmd_wr && (cmd_code == K_ABORT);
        start_evt = cmd_wr && (cmd_code == K_START) && (phase_q == PH_IDLE);
        end_evt   = cmd_wr && (cmd_code == K_END)   && (phase_q == PH_RECV);
    end

    // Output buffer load strobes for the three kinds of response byte.
    always_comb begin
        load_head = (phase_q == PH_WAIT) && rsp_valid && !obf && !abort_evt;
        load_body = (phase_q == PH_BODY) && rsp_valid && !obf && !abort_evt;
        load_tail = (phase_q == PH_TAIL) && !obf && !abort_evt;
    end

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        if (abort_evt) begin
            phase_d = PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE:  if (start_evt) phase_d = PH_RECV;
                PH_RECV:  if (end_evt)   phase_d = PH_WAIT;
                PH_WAIT:  if (load_head) phase_d = PH_BODY;
                PH_BODY:  if (load_body && rsp_last) phase_d = PH_TAIL;
                PH_TAIL:  if (load_tail) phase_d = PH_DRAIN;
                PH_DRAIN: if (!obf)      phase_d = PH_IDLE;
                default:  phase_d = PH_IDLE;
            endcase
        end
    end

    // Phase register and registered event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            frame_end   <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            phase_q     <= phase_d;
            frame_end   <= end_evt;
            abort_pulse <= abort_evt;
        end
    end

    assign phase = phase_q;

    // R9: a cancel always lands in the idle phase
    a_r9_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |=> (phase_q == PH_IDLE));
    // R11: an end code while idle changes nothing
    a_r11_end_in_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && cmd_wr && cmd_code == K_END) |=> (phase_q == PH_IDLE));
    // R5: the end-of-frame pulse only follows the receive phase
    a_r5_end_from_recv: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> ($past(phase_q) == PH_RECV && phase_q == PH_WAIT));
    // R8: the tail byte is loaded only after a body byte marked last
    a_r8_tail_after_body: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_TAIL && $past(phase_q) != PH_TAIL) |-> $past(load_body && rsp_last));
endmodule

// File: rtl/mbx_in_buf.sv
`timescale 1ns/1ps
// Input holding register: one host byte toward the core.
// Accepts a host data write only when the receive phase is open and the register
// is empty; anything else is dropped and flagged in a sticky error bit.
module mbx_in_buf #(
    parameter int DATA_W = mbx_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              accept_en,
    input  logic              take,
    input  logic              clr,
    input  logic              clr_err,
    output logic              ibf,
    output logic [DATA_W-1:0] ibuf,
    output logic              err
);
    logic wr_ok;

    // A write is accepted only with the receive phase open and the register empty.
    always_comb wr_ok = wr && accept_en && !ibf;

    // Holding register, full flag and sticky drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibf  <= 1'b0;
            ibuf <= '0;
            err  <= 1'b0;
        end else begin
            if (clr) begin
                ibf  <= 1'b0;
                ibuf <= '0;
            end else if (wr_ok) begin
                ibf  <= 1'b1;
                ibuf <= wdata;
            end else if (take && ibf) begin
                ibf  <= 1'b0;
            end
            if (clr_err)
                err <= 1'b0;
            else if (wr && !wr_ok)
                err <= 1'b1;
        end
    end

    // R4: a dropped write leaves the held byte untouched
    a_r4_drop_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !(accept_en && !ibf) && !clr) |=> ($stable(ibuf) && err));
    // R3: a taken byte empties the register on the next cycle
    a_r3_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (ibf && take) |=> !ibf);
endmodule

// File: rtl/mbx_out_buf.sv
`timescale 1ns/1ps
// Output holding register: one byte toward the host, with the frame-marker flag.
// Head and tail loads insert the fixed framing bytes; body loads pass core data.
// A host data read empties it. Assumes at most one load strobe per cycle.
module mbx_out_buf #(
    parameter int DATA_W = mbx_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_head,
    input  logic              load_body,
    input  logic              load_tail,
    input  logic [DATA_W-1:0] body_data,
    input  logic              rd,
    input  logic              clr,
    output logic              obf,
    output logic              mrk,
    output logic [DATA_W-1:0] obuf
);
    import mbx_pkg::*;

    localparam logic [DATA_W-1:0] K_HEAD = DATA_W'(CODE_START);
    localparam logic [DATA_W-1:0] K_TAIL = DATA_W'(CODE_END);

    logic [DATA_W-1:0] load_val;
    logic              load_any;

    // Pick the byte to load.
    always_comb begin
        load_any = load_head || load_body || load_tail;
        if (load_head)      load_val = K_HEAD;
        else if (load_tail) load_val = K_TAIL;
        else                load_val = body_data;
    end

    // Buffer, full flag and frame marker.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            obf  <= 1'b0;
            mrk  <= 1'b0;
            obuf <= '0;
        end else if (load_any) begin
            obf  <= 1'b1;
            mrk  <= load_head || load_tail;
            obuf <= load_val;
        end else if (rd) begin
            obf  <= 1'b0;
            mrk  <= 1'b0;
        end
    end

    // R7: no load may overwrite an unread byte
    a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        obf |-> !(load_head || load_body || load_tail));
    // R6: the full flag rises only from a load
    a_r6_full_from_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(obf) |-> $past(load_head || load_body || load_tail));
    // R6: the marker is only ever seen with a full buffer
    a_r6_marker_with_full: assert property (@(posedge clk) disable iff (!rst_n)
        mrk |-> obf);
endmodule

// File: rtl/cmd_mailbox.sv
`timescale 1ns/1ps
// Top level of the byte-wide command/response mailbox.
// Host side: one-bit address bus (0 = data, 1 = status/command).
// Core side: request byte stream out, response byte stream in.
// Assumes one host access per cycle, strobe held for one cycle.
module cmd_mailbox #(
    parameter int DATA_W = mbx_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic              host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              req_valid,
    output logic [DATA_W-1:0] req_data,
    input  logic              req_ready,
    output logic              req_end,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              rsp_last,
    output logic              rsp_ready,
    output logic              cancel_done,
    output logic              data_err
);
    import mbx_pkg::*;

    logic            cmd_wr, data_wr, data_rd;
    phase_t          phase;
    logic            start_evt, abort_evt;
    logic            load_head, load_body, load_tail;
    logic            ibf, obf, mrk, cmw_q;
    logic            rdy_cmd, rdy_dat;
    logic [DATA_W-1:0] obuf, status;

    // Split host accesses by address and direction.
    always_comb begin
        cmd_wr  = host_sel &&  host_wr &&  host_addr;
        data_wr = host_sel &&  host_wr && !host_addr;
        data_rd = host_sel && !host_wr && !host_addr;
    end

    mbx_cmd_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_code   (host_wdata),
        .obf        (obf),
        .rsp_valid  (rsp_valid),
        .rsp_last   (rsp_last),
        .phase      (phase),
        .start_evt  (start_evt),
        .abort_evt  (abort_evt),
        .load_head  (load_head),
        .load_body  (load_body),
        .load_tail  (load_tail),
        .frame_end  (req_end),
        .abort_pulse(cancel_done)
    );

    mbx_in_buf #(.DATA_W(DATA_W)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (data_wr),
        .wdata    (host_wdata),
        .accept_en(phase == PH_RECV),
        .take     (req_ready),
        .clr      (abort_evt),
        .clr_err  (start_evt),
        .ibf      (ibf),
        .ibuf     (req_data),
        .err      (data_err)
    );

    mbx_out_buf #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_head(load_head),
        .load_body(load_body),
        .load_tail(load_tail),
        .body_data(rsp_data),
        .rd       (data_rd),
        .clr      (abort_evt),
        .obf      (obf),
        .mrk      (mrk),
        .obuf     (obuf)
    );

    // Remember whether the last host write went to the command offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmw_q <= 1'b0;
        else if (host_sel && host_wr)
            cmw_q <= host_addr;
    end

    // Assemble the status byte and the read mux.
    always_comb begin
        rdy_cmd = (phase == PH_IDLE);
        rdy_dat = (phase == PH_RECV);
        status  = '0;
        status[ST_OBF] = obf;
        status[ST_IBF] = ibf;
        status[ST_MRK] = mrk;
        status[ST_CMW] = cmw_q;
        status[ST_RDC] = rdy_cmd;
        status[ST_RDD] = rdy_dat;
        host_rdata = host_addr ? status : obuf;
        req_valid  = ibf;
        rsp_ready  = load_body;
    end

    // R12: the two ready flags are never set at once
    a_r12_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rdy_cmd, rdy_dat}));
    // R8: ready-for-command only with both holding registers empty
    a_r8_idle_is_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_cmd && $past(phase) == PH_DRAIN) |-> (!obf && !ibf));
    // R7: a response byte is taken only into an empty output buffer
    a_r7_take_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> (obf && !mrk));
    // R9: cancel leaves both holding registers empty
    a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |=> (!obf && !ibf && !mrk));
endmodule

// File: tb/cmd_mailbox_test.sv
`timescale 1ns/1ps
// Directed bench for cmd_mailbox: one task per scenario.
module cmd_mailbox_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0, host_wr = 1'b0, host_addr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       req_valid;
    logic [7:0] req_data;
    logic       req_ready = 1'b0;
    logic       req_end;
    logic       rsp_valid = 1'b0;
    logic [7:0] rsp_data = 8'h00;
    logic       rsp_last = 1'b0;
    logic       rsp_ready, cancel_done, data_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    cmd_mailbox uut (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .req_valid(req_valid), .req_data(req_data), .req_ready(req_ready),
        .req_end(req_end),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .rsp_ready(rsp_ready), .cancel_done(cancel_done), .data_err(data_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic host_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_sel = 1'b0;
    endtask

    task automatic poll_status(input logic [7:0] mask, input logic [7:0] val, output logic [7:0] st);
        st = 8'h00;
        for (int i = 0; i < 20; i++) begin
            host_read(1'b1, st);
            if ((st & mask) == val) break;
        end
    endtask

    task automatic core_take();
        @(negedge clk); req_ready = 1'b1;
        @(negedge clk); req_ready = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        logic [7:0] st;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        host_read(1'b1, st);
        chk("R1 status after reset", st, 8'h10);
        chk("R1 req_valid after reset", req_valid, 1'b0);
        chk("R1 data_err after reset", data_err, 1'b0);
    endtask

    // R2, R3, R4, R10: start a frame and pass bytes to the core
    task automatic t_receive();
        logic [7:0] st;
        host_write(1'b0, 8'h77);             // data write while idle: dropped
        chk("R4 err on idle data write", data_err, 1'b1);
        chk("R4 idle write not forwarded", req_valid, 1'b0);
        host_write(1'b1, 8'h01);
        chk("R4 err cleared by start", data_err, 1'b0);
        host_read(1'b1, st);
        chk("R2 R10 status after start", st, 8'h28);
        chk("R12 upper bits zero", st[7:6], 2'b00);
        host_write(1'b0, 8'hA5);
        host_read(1'b1, st);
        chk("R3 R10 status with byte held", st, 8'h22);
        chk("R3 req_valid", req_valid, 1'b1);
        chk("R3 req_data", req_data, 8'hA5);
        host_write(1'b0, 8'h3C);             // overrun: dropped
        chk("R4 err on overrun", data_err, 1'b1);
        chk("R4 held byte kept", req_data, 8'hA5);
        core_take();
        chk("R3 flag cleared after take", req_valid, 1'b0);
        host_read(1'b1, st);
        chk("R3 status after take", st, 8'h20);
    endtask

    // R5: close the frame
    task automatic t_end();
        logic [7:0] st;
        chk("R5 no end pulse before", req_end, 1'b0);
        host_write(1'b1, 8'h03);
        chk("R5 end pulse", req_end, 1'b1);
        @(negedge clk);
        chk("R5 end pulse is one cycle", req_end, 1'b0);
        host_read(1'b1, st);
        chk("R5 status after end", st, 8'h08);
    endtask

    // R6, R7, R8: framed response of six bytes with length 6 in bytes 2..5
    task automatic t_response();
        logic [7:0] pay [6] = '{8'h00, 8'hC4, 8'h00, 8'h00, 8'h00, 8'h06};
        logic [7:0] st, d;
        int k;
        @(negedge clk);
        rsp_valid = 1'b1; rsp_data = pay[0]; rsp_last = 1'b0;
        poll_status(8'h01, 8'h01, st);
        chk("R6 head status", st, 8'h0D);
        chk("R6 core byte not taken at head", rsp_ready, 1'b0);
        host_read(1'b0, d);
        chk("R6 head byte", d, 8'h01);
        for (int i = 0; i < 6; i++) begin
            k = 0;
            while (!rsp_ready && k < 20) begin @(negedge clk); k++; end
            chk("R7 ready pulse seen", rsp_ready, 1'b1);
            @(negedge clk);
            if (i < 5) begin
                rsp_data = pay[i+1]; rsp_last = (i + 1 == 5);
            end else begin
                rsp_valid = 1'b0; rsp_last = 1'b0;
            end
            poll_status(8'h01, 8'h01, st);
            chk("R7 body status marker clear", st, 8'h09);
            host_read(1'b0, d);
            chk("R7 body byte in order", d, pay[i]);
        end
        poll_status(8'h01, 8'h01, st);
        chk("R8 tail status", st, 8'h0D);
        host_read(1'b0, d);
        chk("R8 tail byte", d, 8'h03);
        poll_status(8'h10, 8'h10, st);
        chk("R8 ready-for-command returns", st, 8'h18);
    endtask

    // R9: cancel while receiving and while answering
    task automatic t_cancel();
        logic [7:0] st;
        host_write(1'b1, 8'h01);
        host_write(1'b0, 8'h5A);
        chk("R9 byte held before cancel", req_valid, 1'b1);
        host_write(1'b1, 8'h22);
        chk("R9 cancel pulse", cancel_done, 1'b1);
        chk("R9 input emptied", req_valid, 1'b0);
        host_read(1'b1, st);
        chk("R9 status after cancel in receive", st, 8'h18);
        host_write(1'b1, 8'h01);
        host_write(1'b1, 8'h03);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_data = 8'h99; rsp_last = 1'b0;
        poll_status(8'h01, 8'h01, st);
        chk("R9 head loaded before cancel", st, 8'h0D);
        host_write(1'b1, 8'h22);
        rsp_valid = 1'b0;
        host_read(1'b1, st);
        chk("R9 status after cancel in response", st, 8'h18);
    endtask

    // R11, R12: codes that do not fit the phase
    task automatic t_ignored();
        logic [7:0] st;
        host_write(1'b1, 8'h03);
        chk("R11 no end pulse from idle", req_end, 1'b0);
        host_read(1'b1, st);
        chk("R11 idle unchanged by end code", st, 8'h18);
        host_write(1'b1, 8'h01);
        host_write(1'b1, 8'h01);
        host_read(1'b1, st);
        chk("R11 R12 start while receiving ignored", st, 8'h28);
        host_write(1'b1, 8'h22);
        host_read(1'b1, st);
        chk("R9 cleanup cancel", st, 8'h18);
    endtask

    initial begin
        t_reset();
        t_receive();
        t_end();
        t_response();
        t_cancel();
        t_ignored();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule